// File: doc/BRIEF.md
# Time Alarm Comparator and Interrupt Status Flags

This block watches a real-time clock's update strobe. One cycle after each time increment completes, it compares the live seconds, minutes and hour bytes against three stored alarm bytes. An alarm byte whose two top bits are both set is a wildcard and matches any value. When all three fields match, the block raises an alarm flag.

The same compare cycle also raises an update-ended flag. A periodic tick from the rate generator raises a periodic flag. These three flags sit in one status byte, together with a summary bit that mirrors the interrupt line. The interrupt line is driven only for flags whose enable input is on. Reading the status byte returns the pending flags and clears them.

The time counter and the rate generator are outside the block. The enables come from a control register held elsewhere.

Top module: `rtc_alarm_flags`

## Requirements
- R1: After reset the status byte reads 0x00, the interrupt line is low and all three alarm bytes are 0x00.
- R2: When `upd_done` is high in the cycle before clock edge k, the update flag (status bit 4) is set after edge k+1.
- R3: A non-wildcard alarm field matches only when it equals the whole live byte. For the hour this includes bit 7, the PM bit in 12-hour mode: an hour alarm of 0x82 matches hour 0x82 and does not match 0x02, and an alarm of 0x02 does not match 0x82.
- R4: An alarm byte with bits 7 and 6 both set (0xC0 to 0xFF) matches any value of its field.
- R5: The alarm flag (status bit 5) is set on the same edge as the update flag when all three fields match. This happens whether or not `en_alarm` is on.
- R6: A `per_tick` pulse sets the periodic flag (status bit 6) at the next clock edge.
- R7: `irq` is high while (bit 6 and `en_periodic`) or (bit 5 and `en_alarm`) or (bit 4 and `en_update`) holds. Status bit 7 always equals `irq`. Bits 3 to 0 read as 0.
- R8: `stat_data` is the current status byte. A cycle with `stat_rd` high clears the flags at the edge that ends it, so a second read returns 0x00. A flag that is set on that same edge survives the clear.
- R9: `alm_wr` loads `alm_wdata` into the alarm byte picked by `alm_sel`: 0 for seconds, 1 for minutes, 2 for hours. A write with select 3 changes no alarm byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_done | input | 1 | One-cycle strobe: time increment has completed |
| per_tick | input | 1 | One-cycle periodic rate event |
| cur_sec | input | 8 | Live seconds byte |
| cur_min | input | 8 | Live minutes byte |
| cur_hour | input | 8 | Live hour byte, bit 7 = PM in 12-hour mode |
| alm_wr | input | 1 | Alarm byte write strobe |
| alm_sel | input | 2 | Alarm byte select: 0 sec, 1 min, 2 hour, 3 none |
| alm_wdata | input | 8 | Alarm byte write data |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| stat_data | output | 8 | Status byte: 7 summary, 6 periodic, 5 alarm, 4 update |
| irq | output | 1 | Interrupt request line |

## Verification
The hardest case to reach from the ports is a status read that lands on the very edge where a new flag is set. The stimulus must drop `upd_done` and raise `stat_rd` on the same falling edge, so that the delayed compare and the clear fall together. The bench does this and then expects the first read to return the old byte and a second read to still show the update flag. The PM-bit cases are reached by loading hour alarms of 0x82 and 0x02 and presenting both the AM and PM forms of the live hour.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_FIELD = 3;
  localparam int unsigned SEL_W   = $clog2(N_FIELD + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HOUR = 2'd2,
    SEL_NONE = 2'd3
  } alm_sel_e;

  localparam int unsigned BIT_SUM = 7;
  localparam int unsigned BIT_PER = 6;
  localparam int unsigned BIT_ALM = 5;
  localparam int unsigned BIT_UPD = 4;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } flag_t;
endpackage

// File: rtl/rtc_alm_store.sv
module rtc_alm_store
  import rtc_alm_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned NF = N_FIELD,
  parameter int unsigned SW = SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [NF*DW-1:0] alm_bytes
);
  logic [DW-1:0] byte_q [NF];
  logic [DW-1:0] byte_d [NF];
  logic [NF-1:0] hit;

  for (genvar g = 0; g < NF; g++) begin : g_byte
    assign hit[g] = wr_en && (wr_sel == SW'(g));

    always_comb begin
      byte_d[g] = byte_q[g];
      if (hit[g]) byte_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      byte_q[g] <= '0;
      else if (hit[g]) byte_q[g] <= byte_d[g];
    end

    assign alm_bytes[g*DW +: DW] = byte_q[g];
  end
endmodule

// File: rtl/rtc_alm_field_cmp.sv
module rtc_alm_field_cmp
  import rtc_alm_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic [DW-1:0] alm_byte,
  input  logic [DW-1:0] live_byte,
  output logic          match
);
  logic wild;
  logic equal;

  assign wild  = &alm_byte[DW-1:DW-2];
  assign equal = (alm_byte == live_byte);
  assign match = wild | equal;
endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
  import rtc_alm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  flag_t set_ev,
  input  logic  clr,
  input  flag_t enables,
  output flag_t flags,
  output logic  irq_o
);
  flag_t flg_q;
  flag_t flg_d;
  logic  chg;

  always_comb begin
    flg_d = clr ? flag_t'('0) : flg_q;
    flg_d = flag_t'(flg_d | set_ev);
  end

  assign chg = clr | (|set_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flg_q <= '0;
    else if (chg) flg_q <= flg_d;
  end

  assign flags = flg_q;
  assign irq_o = |(flg_q & enables);
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_alm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_done,
  input  logic       per_tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic       alm_wr,
  input  logic [1:0] alm_sel,
  input  logic [7:0] alm_wdata,
  input  logic       en_periodic,
  input  logic       en_alarm,
  input  logic       en_update,
  input  logic       stat_rd,
  output logic [7:0] stat_data,
  output logic       irq
);
  localparam int unsigned DW = BYTE_W;
  localparam int unsigned NF = N_FIELD;

  logic [NF*DW-1:0] alm_bytes;
  logic [NF*DW-1:0] live_bytes;
  logic [NF-1:0]    fld_match;
  logic             cmp_q;
  logic             cmp_d;
  flag_t            set_ev;
  flag_t            enables;
  flag_t            flags;
  logic             irq_int;

  rtc_alm_store #(.DW(DW), .NF(NF), .SW(SEL_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (alm_wr),
    .wr_sel   (alm_sel),
    .wr_data  (alm_wdata),
    .alm_bytes(alm_bytes)
  );

  assign live_bytes = {cur_hour, cur_min, cur_sec};

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    rtc_alm_field_cmp #(.DW(DW)) u_cmp (
      .alm_byte (alm_bytes[g*DW +: DW]),
      .live_byte(live_bytes[g*DW +: DW]),
      .match    (fld_match[g])
    );
  end

  assign cmp_d = upd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_d;
  end

  always_comb begin
    set_ev.per = per_tick;
    set_ev.upd = cmp_q;
    set_ev.alm = cmp_q & (&fld_match);
  end

  assign enables = '{per: en_periodic, alm: en_alarm, upd: en_update};

  rtc_alm_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (set_ev),
    .clr    (stat_rd),
    .enables(enables),
    .flags  (flags),
    .irq_o  (irq_int)
  );

  always_comb begin
    stat_data          = '0;
    stat_data[BIT_SUM] = irq_int;
    stat_data[BIT_PER] = flags.per;
    stat_data[BIT_ALM] = flags.alm;
    stat_data[BIT_UPD] = flags.upd;
  end

  assign irq = irq_int;
endmodule

// File: rtl/rtc_alarm_flags_chk.sv
module rtc_alarm_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_done,
  input logic       per_tick,
  input logic       en_periodic,
  input logic       en_alarm,
  input logic       en_update,
  input logic       stat_rd,
  input logic [7:0] stat_data,
  input logic       irq
);
  AST_UPD_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_done) |=> stat_data[4]); // R2

  AST_ALARM_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_data[5]) |-> $past(upd_done, 2)); // R5

  AST_PER_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> stat_data[6]); // R6

  AST_IRQ_QUIET_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_periodic && !en_alarm && !en_update) |-> !irq); // R7

  AST_SUMMARY_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data[7] == irq) && (stat_data[3:0] == 4'h0)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !$past(upd_done) && !per_tick) |=> (stat_data[6:4] == 3'b000)); // R8
endmodule

bind rtc_alarm_flags rtc_alarm_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_done   (upd_done),
  .per_tick   (per_tick),
  .en_periodic(en_periodic),
  .en_alarm   (en_alarm),
  .en_update  (en_update),
  .stat_rd    (stat_rd),
  .stat_data  (stat_data),
  .irq        (irq)
);

// File: tb/rtc_alarm_flags_bench.sv
module rtc_alarm_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       upd_done;
  logic       per_tick;
  logic [7:0] cur_sec;
  logic [7:0] cur_min;
  logic [7:0] cur_hour;
  logic       alm_wr;
  logic [1:0] alm_sel;
  logic [7:0] alm_wdata;
  logic       en_periodic;
  logic       en_alarm;
  logic       en_update;
  logic       stat_rd;
  logic [7:0] stat_data;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  rtc_alarm_flags u_rtc_alarm_flags (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .per_tick(per_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .alm_wr(alm_wr), .alm_sel(alm_sel), .alm_wdata(alm_wdata),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .stat_rd(stat_rd), .stat_data(stat_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: samples a quarter period after the falling edge, before the clearing edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && stat_rd) begin
      if (exp_q.size() == 0) begin
        check(stat_data, 'hEE, "scoreboard empty");
      end else begin
        check(stat_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic read_expect(input int exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wr_alarm(input int sel, input int val);
    @(negedge clk); alm_wr = 1'b1; alm_sel = 2'(sel); alm_wdata = 8'(val);
    @(negedge clk); alm_wr = 1'b0;
  endtask

  // present a time and strobe; flags are visible after the second following edge
  task automatic update(input int h, input int m, input int s);
    @(negedge clk); cur_hour = 8'(h); cur_min = 8'(m); cur_sec = 8'(s); upd_done = 1'b1;
    @(negedge clk); upd_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic sample_irq(input int exp, input string tag);
    @(negedge clk); #(CLK_PERIOD/4);
    check(irq, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd_done = 0; per_tick = 0; cur_sec = 0; cur_min = 0; cur_hour = 0;
    alm_wr = 0; alm_sel = 0; alm_wdata = 0; en_periodic = 0; en_alarm = 0; en_update = 0;
    stat_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sample_irq(0, "R1 irq after reset");
    read_expect('h00, "R1 status after reset");
    // R1: alarm bytes reset to 0x00, so time 00:00:00 matches
    update('h00, 'h00, 'h00);
    read_expect('h30, "R1 reset alarm bytes match 00:00:00");

    // R4: seconds alarm 0x05, minutes and hours wildcard
    wr_alarm(0, 'h05); wr_alarm(1, 'hC0); wr_alarm(2, 'hFF);
    update('h04, 'h00, 'h04);
    read_expect('h10, "R2 update flag only, no alarm");
    read_expect('h00, "R8 second read returns zero");
    wr_alarm(3, 'h07); // R9 select 3 must not touch seconds alarm
    update('h13, 'h27, 'h05);
    read_expect('h30, "R4 R9 wildcard alarm fires at second 05");
    sample_irq(0, "R5 irq low with alarm enable off");

    // R5/R7: flag set with enable off, then enabling raises irq
    update('h13, 'h27, 'h05);
    en_alarm = 1'b1;
    sample_irq(1, "R7 irq with alarm enable on");
    read_expect('hB0, "R7 summary bit mirrors irq");
    sample_irq(0, "R8 irq drops after read clear");
    en_alarm = 1'b0;

    // R3: PM bit in the hour compare
    wr_alarm(0, 'h00); wr_alarm(1, 'h00); wr_alarm(2, 'h82);
    update('h02, 'h00, 'h00);
    read_expect('h10, "R3 alarm 0x82 does not fire at 0x02");
    update('h82, 'h00, 'h00);
    read_expect('h30, "R3 alarm 0x82 fires at 0x82");
    wr_alarm(2, 'h02);
    update('h82, 'h00, 'h00);
    read_expect('h10, "R3 alarm 0x02 does not fire at 0x82");
    wr_alarm(2, 'h80); // top bits 10 is not a wildcard
    update('h81, 'h00, 'h00);
    read_expect('h10, "R4 0x80 is not a wildcard");

    // R6: periodic flag and enable
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
    read_expect('h40, "R6 periodic flag");
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
    en_periodic = 1'b1;
    sample_irq(1, "R7 periodic irq");
    en_periodic = 1'b0;
    sample_irq(0, "R7 irq follows enable");
    read_expect('h40, "R7 summary clear with enable off");

    // R7: update enable
    en_update = 1'b1;
    update('h01, 'h01, 'h01);
    read_expect('h90, "R7 update irq summary");
    en_update = 1'b0;

    // R8: read on the same edge as a new update flag
    @(negedge clk); cur_hour = 'h01; cur_min = 'h01; cur_sec = 'h02; upd_done = 1'b1;
    @(negedge clk); upd_done = 1'b0; stat_rd = 1'b1;
    exp_q.push_back('h00); tag_q.push_back("R8 read before concurrent set");
    @(negedge clk); stat_rd = 1'b0;
    read_expect('h10, "R8 flag set on clearing edge survives");
    read_expect('h00, "R8 cleared afterwards");

    repeat (4) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule